// File: doc/BRIEF.md
# Shared-Buffer Multicast Cell Switching Element

This block is an S-by-S cell switch in which every accepted cell is kept in one common cell store. Each outlet is fed from its own queue of store addresses, so the switch queues at the outputs. Every inlet may present one cell per clock (one slot). The cell carries a connection index. A programmable route table turns that index into a bitmask of target outlets. The payload is written into a single free store slot. That slot's address is then appended to the address queue of every outlet named in the mask, so a multicast cell costs one store slot however many outlets it reaches.

Each outlet whose queue holds an entry emits one cell per slot. Every store slot carries a count of the copies still owed. The count drops on each transmission from the slot, and the slot returns to the free pool once the count is exhausted. A cell that cannot be placed whole is dropped whole and counted. A cell whose mask is empty is simply discarded. The route table is written through its own port and has no effect on cells already queued.

Top module: `mcast_shared_switch`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is all zeros and `drop_count` is zero. Reset clears every route table entry to an empty mask, so cells arriving before programming are discarded.
- R2: A cell accepted at a rising edge is enqueued at that edge. If the target outlet's queue was empty, the cell is presented on that outlet (valid high, payload on its lane) in the cycle that follows the next rising edge. Each outlet presents at most one cell per cycle.
- R3: A cell whose table entry has bit o set for exactly the outlets {0,1,3} appears exactly once on outlets 0, 1 and 3 and never on outlet 2. In general a cell appears exactly once on each outlet of its mask and on no other outlet.
- R4: Each outlet emits its cells in acceptance order. Cells accepted in the same slot are ordered by inlet number, inlet 0 first.
- R5: An arriving cell whose table mask is all zeros takes no store slot, produces no output and does not change `drop_count`.
- R6: A cell is dropped whole if no store slot is free, or if any selected outlet's queue is full. Queue fullness counts the queue occupancy at the start of the slot plus the copies already granted to lower-numbered inlets in that slot. No copy of a dropped cell is sent, and `drop_count` rises by one per dropped cell.
- R7: Free slots at the start of a slot are handed to the accepted cells of that slot in inlet order. A slot is released in the slot in which its last copy is sent and may be reused from the next slot on. After all traffic drains, the full store capacity is available again.
- R8: A table write (`tbl_we` high at a rising edge) applies to cells arriving from the next edge on. Cells already queued keep the outlets they were given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one slot |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORT | Per-inlet cell present |
| in_conn | input | NPORT*CONN_W | Per-inlet connection index, inlet i in bits [i*CONN_W +: CONN_W] |
| in_cell | input | NPORT*CELL_W | Per-inlet payload, inlet i in bits [i*CELL_W +: CELL_W] |
| tbl_we | input | 1 | Route table write enable |
| tbl_addr | input | CONN_W | Route table entry to write |
| tbl_mask | input | NPORT | Outlet mask to store, bit o selects outlet o |
| out_valid | output | NPORT | Per-outlet cell present |
| out_cell | output | NPORT*CELL_W | Per-outlet payload, outlet o in bits [o*CELL_W +: CELL_W] |
| drop_count | output | DROP_W | Number of dropped cells since reset |

## Verification
Acceptance, slot allocation, queue pushes and drop counting all take effect at the edge that samples the arrival. A cell therefore reaches an idle outlet one edge later, and a cell behind others leaves one slot after its predecessor. `drop_count` shows a drop right after the sampling edge. A freed slot is reusable one edge after its last copy leaves, and a table write applies from the edge after the write. The bench advances a behavioural model of the per-outlet queues, the free-slot count and the table at each rising edge, in the same order. It compares every outlet lane and the drop count at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/mss_pkg.sv
package mss_pkg;

    // Width of an index into n entries, never below one bit.
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Per-inlet outcome of admission in one slot.
    typedef enum logic [1:0] {
        ADM_NONE    = 2'd0,
        ADM_DISCARD = 2'd1,
        ADM_DROP    = 2'd2,
        ADM_ACCEPT  = 2'd3
    } adm_verdict_e;

endpackage

// File: rtl/mss_route_table.sv
module mss_route_table #(
    parameter int NPORT  = 4,
    parameter int CONN_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [CONN_W-1:0]       waddr,
    input  logic [NPORT-1:0]        wmask,
    input  logic [NPORT*CONN_W-1:0] lk_idx,
    output logic [NPORT*NPORT-1:0]  lk_mask
);
    localparam int ENTRIES = 1 << CONN_W;

    logic [NPORT-1:0] entry_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) entry_q[e] <= '0;
        end else if (we) begin
            entry_q[waddr] <= wmask;
        end
    end

    // Combinational lookup: writes in this slot apply from the next one.
    always_comb begin
        for (int i = 0; i < NPORT; i++)
            lk_mask[i*NPORT +: NPORT] = entry_q[lk_idx[i*CONN_W +: CONN_W]];
    end

endmodule

// File: rtl/mss_admit.sv
module mss_admit
    import mss_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int BUF_DEPTH = 16,
    parameter int Q_DEPTH   = 8
) (
    input  logic [NPORT-1:0]                       in_valid,
    input  logic [NPORT*NPORT-1:0]                 lk_mask,
    input  logic [BUF_DEPTH-1:0]                   free_map,
    input  logic [NPORT*$clog2(Q_DEPTH+1)-1:0]     q_count,
    output logic [NPORT-1:0]                       acc,
    output logic [NPORT*idx_width(BUF_DEPTH)-1:0]  slot,
    output logic [NPORT*NPORT-1:0]                 push,      // [o*NPORT + i]
    output logic [NPORT*$clog2(NPORT+1)-1:0]       copies,
    output logic [$clog2(NPORT+1)-1:0]             n_drop
);
    localparam int SLOT_W = idx_width(BUF_DEPTH);
    localparam int QC_W   = $clog2(Q_DEPTH+1);
    localparam int CP_W   = $clog2(NPORT+1);

    adm_verdict_e         verdict [NPORT];
    logic [BUF_DEPTH-1:0] avail;
    int                   occ [NPORT];
    logic [NPORT-1:0]     mask;
    logic                 fits;
    logic                 found;
    int                   pick;

    always_comb begin
        avail  = free_map;
        n_drop = '0;
        acc    = '0;
        slot   = '0;
        push   = '0;
        copies = '0;
        mask   = '0;
        fits   = 1'b0;
        found  = 1'b0;
        pick   = 0;
        for (int o = 0; o < NPORT; o++) occ[o] = int'(q_count[o*QC_W +: QC_W]);
        for (int i = 0; i < NPORT; i++) begin
            verdict[i] = ADM_NONE;
            mask = lk_mask[i*NPORT +: NPORT];
            if (in_valid[i]) begin
                if (mask == '0) begin
                    verdict[i] = ADM_DISCARD;
                end else begin
                    fits = 1'b1;
                    for (int o = 0; o < NPORT; o++)
                        if (mask[o] && occ[o] >= Q_DEPTH) fits = 1'b0;
                    found = 1'b0;
                    pick  = 0;
                    for (int s = BUF_DEPTH-1; s >= 0; s--) begin
                        if (avail[s]) begin
                            found = 1'b1;
                            pick  = s;
                        end
                    end
                    verdict[i] = (fits && found) ? ADM_ACCEPT : ADM_DROP;
                end
            end
            if (verdict[i] == ADM_ACCEPT) begin
                acc[i] = 1'b1;
                avail[pick] = 1'b0;
                slot[i*SLOT_W +: SLOT_W] = SLOT_W'(pick);
                copies[i*CP_W +: CP_W]   = CP_W'($countones(mask));
                for (int o = 0; o < NPORT; o++) begin
                    if (mask[o]) begin
                        push[o*NPORT + i] = 1'b1;
                        occ[o] = occ[o] + 1;
                    end
                end
            end else if (verdict[i] == ADM_DROP) begin
                n_drop = n_drop + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mss_addr_queue.sv
module mss_addr_queue
    import mss_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int Q_DEPTH = 8,
    parameter int SLOT_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPORT-1:0]           push,
    input  logic [NPORT*SLOT_W-1:0]    push_slot,
    input  logic                       pop,
    output logic [SLOT_W-1:0]          head,
    output logic                       empty,
    output logic [$clog2(Q_DEPTH+1)-1:0] count
);
    localparam int PTR_W = idx_width(Q_DEPTH);
    localparam int QC_W  = $clog2(Q_DEPTH+1);

    logic [SLOT_W-1:0] ring [Q_DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [QC_W-1:0]   cnt_q;
    int                off [NPORT];
    int                n_push;

    // Pushes of one slot land in consecutive entries, lowest inlet first.
    always_comb begin
        n_push = 0;
        for (int i = 0; i < NPORT; i++) begin
            off[i] = n_push;
            if (push[i]) n_push = n_push + 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            for (int i = 0; i < NPORT; i++)
                if (push[i])
                    ring[(int'(wr_ptr) + off[i]) % Q_DEPTH] <= push_slot[i*SLOT_W +: SLOT_W];
            wr_ptr <= PTR_W'((int'(wr_ptr) + n_push) % Q_DEPTH);
            if (pop) rd_ptr <= PTR_W'((int'(rd_ptr) + 1) % Q_DEPTH);
            cnt_q <= QC_W'(int'(cnt_q) + n_push - (pop ? 1 : 0));
        end
    end

    assign head  = ring[rd_ptr];
    assign empty = (cnt_q == '0);
    assign count = cnt_q;

endmodule

// File: rtl/mss_cell_store.sv
module mss_cell_store
    import mss_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int BUF_DEPTH = 16,
    parameter int CELL_W    = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NPORT-1:0]                     wr_en,
    input  logic [NPORT*idx_width(BUF_DEPTH)-1:0] wr_slot,
    input  logic [NPORT*CELL_W-1:0]              wr_cell,
    input  logic [NPORT*$clog2(NPORT+1)-1:0]     wr_copies,
    input  logic [NPORT-1:0]                     rd_en,
    input  logic [NPORT*idx_width(BUF_DEPTH)-1:0] rd_slot,
    output logic [NPORT*CELL_W-1:0]              rd_cell,
    output logic [BUF_DEPTH-1:0]                 free_map
);
    localparam int SLOT_W = idx_width(BUF_DEPTH);
    localparam int CP_W   = $clog2(NPORT+1);

    logic [CELL_W-1:0]    mem   [BUF_DEPTH];
    logic [CP_W-1:0]      owed  [BUF_DEPTH];
    logic [CP_W-1:0]      dec   [BUF_DEPTH];
    logic [BUF_DEPTH-1:0] free_q;

    // Copies sent from each slot in this cycle (several outlets may share one).
    always_comb begin
        for (int s = 0; s < BUF_DEPTH; s++) begin
            dec[s] = '0;
            for (int o = 0; o < NPORT; o++)
                if (rd_en[o] && int'(rd_slot[o*SLOT_W +: SLOT_W]) == s) dec[s] = dec[s] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= '1;
            for (int s = 0; s < BUF_DEPTH; s++) owed[s] <= '0;
        end else begin
            for (int s = 0; s < BUF_DEPTH; s++) begin
                if (dec[s] != '0) begin
                    owed[s] <= owed[s] - dec[s];
                    if (owed[s] == dec[s]) free_q[s] <= 1'b1;
                end
            end
            // A written slot was free, so it is never read in the same cycle.
            for (int i = 0; i < NPORT; i++) begin
                if (wr_en[i]) begin
                    mem[wr_slot[i*SLOT_W +: SLOT_W]]    <= wr_cell[i*CELL_W +: CELL_W];
                    owed[wr_slot[i*SLOT_W +: SLOT_W]]   <= wr_copies[i*CP_W +: CP_W];
                    free_q[wr_slot[i*SLOT_W +: SLOT_W]] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++)
            rd_cell[o*CELL_W +: CELL_W] = mem[rd_slot[o*SLOT_W +: SLOT_W]];
    end

    assign free_map = free_q;

endmodule

// File: rtl/mcast_shared_switch.sv
module mcast_shared_switch
    import mss_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int BUF_DEPTH = 16,
    parameter int Q_DEPTH   = 8,
    parameter int CELL_W    = 16,
    parameter int CONN_W    = 4,
    parameter int DROP_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        in_valid,
    input  logic [NPORT*CONN_W-1:0] in_conn,
    input  logic [NPORT*CELL_W-1:0] in_cell,
    input  logic                    tbl_we,
    input  logic [CONN_W-1:0]       tbl_addr,
    input  logic [NPORT-1:0]        tbl_mask,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT*CELL_W-1:0] out_cell,
    output logic [DROP_W-1:0]       drop_count
);
    localparam int SLOT_W = idx_width(BUF_DEPTH);
    localparam int QC_W   = $clog2(Q_DEPTH+1);
    localparam int CP_W   = $clog2(NPORT+1);

    logic [NPORT*NPORT-1:0]  lk_mask;
    logic [BUF_DEPTH-1:0]    free_map;
    logic [NPORT*QC_W-1:0]   q_count;
    logic [NPORT-1:0]        adm_acc;
    logic [NPORT*SLOT_W-1:0] adm_slot;
    logic [NPORT*NPORT-1:0]  adm_push;
    logic [NPORT*CP_W-1:0]   adm_copies;
    logic [CP_W-1:0]         adm_ndrop;
    logic [NPORT*SLOT_W-1:0] q_head;
    logic [NPORT-1:0]        q_empty;
    logic [NPORT-1:0]        rd_en;
    logic [NPORT*CELL_W-1:0] rd_cell;

    mss_route_table #(.NPORT(NPORT), .CONN_W(CONN_W)) u_table (
        .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_addr), .wmask(tbl_mask),
        .lk_idx(in_conn), .lk_mask(lk_mask)
    );

    mss_admit #(.NPORT(NPORT), .BUF_DEPTH(BUF_DEPTH), .Q_DEPTH(Q_DEPTH)) u_admit (
        .in_valid(in_valid), .lk_mask(lk_mask), .free_map(free_map), .q_count(q_count),
        .acc(adm_acc), .slot(adm_slot), .push(adm_push), .copies(adm_copies),
        .n_drop(adm_ndrop)
    );

    mss_cell_store #(.NPORT(NPORT), .BUF_DEPTH(BUF_DEPTH), .CELL_W(CELL_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(adm_acc), .wr_slot(adm_slot), .wr_cell(in_cell),
        .wr_copies(adm_copies), .rd_en(rd_en), .rd_slot(q_head), .rd_cell(rd_cell),
        .free_map(free_map)
    );

    for (genvar o = 0; o < NPORT; o++) begin : g_outq
        mss_addr_queue #(.NPORT(NPORT), .Q_DEPTH(Q_DEPTH), .SLOT_W(SLOT_W)) u_q (
            .clk(clk), .rst(rst),
            .push(adm_push[o*NPORT +: NPORT]), .push_slot(adm_slot),
            .pop(rd_en[o]), .head(q_head[o*SLOT_W +: SLOT_W]),
            .empty(q_empty[o]), .count(q_count[o*QC_W +: QC_W])
        );
    end

    assign rd_en = ~q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= '0;
            out_cell   <= '0;
            drop_count <= '0;
        end else begin
            out_valid <= rd_en;
            for (int o = 0; o < NPORT; o++)
                if (rd_en[o]) out_cell[o*CELL_W +: CELL_W] <= rd_cell[o*CELL_W +: CELL_W];
            drop_count <= drop_count + DROP_W'(adm_ndrop);
        end
    end

endmodule

// File: rtl/mcast_shared_switch_chk.sv
module mcast_shared_switch_chk
    import mss_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int BUF_DEPTH = 16,
    parameter int Q_DEPTH   = 8,
    parameter int DROP_W    = 16
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic [NPORT-1:0]                      in_valid,
    input logic [NPORT*NPORT-1:0]                lk_mask,
    input logic [NPORT-1:0]                      adm_acc,
    input logic [NPORT*idx_width(BUF_DEPTH)-1:0] adm_slot,
    input logic [BUF_DEPTH-1:0]                  free_map,
    input logic [NPORT*$clog2(Q_DEPTH+1)-1:0]    q_count,
    input logic [NPORT-1:0]                      out_valid,
    input logic [DROP_W-1:0]                     drop_count
);
    localparam int SLOT_W = idx_width(BUF_DEPTH);
    localparam int QC_W   = $clog2(Q_DEPTH+1);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_valid == '0 && drop_count == '0))
        else $error("R1: outputs active right after reset");

    p_drop_step_r6: assert property (@(posedge clk) disable iff (rst)
        DROP_W'(drop_count - $past(drop_count)) <= DROP_W'(NPORT))
        else $error("R6: drop counter moved by more than one per inlet");

    always @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NPORT; i++) begin
                if (in_valid[i] && lk_mask[i*NPORT +: NPORT] == '0) begin
                    p_zero_mask_r5: assert (!adm_acc[i])
                        else $error("R5: empty-mask cell took a slot");
                end
                if (adm_acc[i]) begin
                    p_alloc_free_r7: assert (free_map[adm_slot[i*SLOT_W +: SLOT_W]])
                        else $error("R7: occupied slot allocated");
                    for (int j = i + 1; j < NPORT; j++) begin
                        if (adm_acc[j]) begin
                            p_distinct_slot_r7: assert (adm_slot[i*SLOT_W +: SLOT_W] != adm_slot[j*SLOT_W +: SLOT_W])
                                else $error("R7: two cells given one slot");
                        end
                    end
                end
            end
            for (int o = 0; o < NPORT; o++) begin
                p_no_overflow_r6: assert (int'(q_count[o*QC_W +: QC_W]) <= Q_DEPTH)
                    else $error("R6: address queue overfilled");
            end
        end
    end

endmodule

bind mcast_shared_switch mcast_shared_switch_chk #(
    .NPORT(NPORT), .BUF_DEPTH(BUF_DEPTH), .Q_DEPTH(Q_DEPTH), .DROP_W(DROP_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lk_mask(lk_mask), .adm_acc(adm_acc),
    .adm_slot(adm_slot), .free_map(free_map), .q_count(q_count),
    .out_valid(out_valid), .drop_count(drop_count)
);

// File: tb/sim_mcast_shared_switch.sv
`timescale 1ns/1ps
module sim_mcast_shared_switch;
    localparam int NP = 4;
    localparam int BD = 16;
    localparam int QD = 8;
    localparam int CW = 16;
    localparam int XW = 4;
    localparam int DW = 16;
    localparam int IDS = 4096;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   in_valid = '0;
    logic [NP*XW-1:0] in_conn = '0;
    logic [NP*CW-1:0] in_cell = '0;
    logic            tbl_we = 1'b0;
    logic [XW-1:0]   tbl_addr = '0;
    logic [NP-1:0]   tbl_mask = '0;
    logic [NP-1:0]   out_valid;
    logic [NP*CW-1:0] out_cell;
    logic [DW-1:0]   drop_count;

    always #2.5 clk = ~clk;

    mcast_shared_switch #(.NPORT(NP), .BUF_DEPTH(BD), .Q_DEPTH(QD), .CELL_W(CW),
                          .CONN_W(XW), .DROP_W(DW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_conn(in_conn), .in_cell(in_cell),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_mask(tbl_mask),
        .out_valid(out_valid), .out_cell(out_cell), .drop_count(drop_count)
    );

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R1";
    int    seen [NP];
    int    pay_seq = 1;

    // Reference model state
    int             mq [NP][$];
    logic [CW-1:0]  cpay [IDS];
    int             refs [IDS];
    int             free_cnt = BD;
    int             next_id = 0;
    logic [NP-1:0]  mtab [1<<XW];
    int             mdrop = 0;
    logic [NP-1:0]  exp_v = '0;
    logic [CW-1:0]  exp_d [NP];
    int             popped [NP];
    int             occ [NP];
    int             avail;
    logic [NP-1:0]  m;
    bit             fits;
    int             freed;

    task automatic fail(input string what, input logic [63:0] act, input logic [63:0] expv);
        errors++;
        $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, expv);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Model advances at each rising edge: pops first, then admissions, then frees and table.
    always @(posedge clk) begin
        if (rst) begin
            for (int o = 0; o < NP; o++) mq[o].delete();
            free_cnt = BD;
            mdrop = 0;
            exp_v = '0;
            for (int e = 0; e < (1<<XW); e++) mtab[e] = '0;
        end else begin
            for (int o = 0; o < NP; o++) begin
                occ[o] = mq[o].size();
                popped[o] = -1;
                exp_v[o] = 1'b0;
                if (mq[o].size() > 0) begin
                    popped[o] = mq[o].pop_front();
                    exp_v[o] = 1'b1;
                    exp_d[o] = cpay[popped[o]];
                end
            end
            avail = free_cnt;
            for (int i = 0; i < NP; i++) begin
                if (in_valid[i]) begin
                    m = mtab[in_conn[i*XW +: XW]];
                    if (m != '0) begin
                        fits = 1;
                        for (int o = 0; o < NP; o++) if (m[o] && occ[o] >= QD) fits = 0;
                        if (fits && avail > 0) begin
                            cpay[next_id] = in_cell[i*CW +: CW];
                            refs[next_id] = $countones(m);
                            avail--;
                            for (int o = 0; o < NP; o++) begin
                                if (m[o]) begin
                                    mq[o].push_back(next_id);
                                    occ[o]++;
                                end
                            end
                            next_id = (next_id + 1) % IDS;
                        end else begin
                            mdrop++;
                        end
                    end
                end
            end
            freed = 0;
            for (int o = 0; o < NP; o++) begin
                if (popped[o] >= 0) begin
                    refs[popped[o]]--;
                    if (refs[popped[o]] == 0) freed++;
                end
            end
            free_cnt = avail + freed;
            if (tbl_we) mtab[tbl_addr] = tbl_mask;
        end
    end

    // Compare every lane at each falling edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int o = 0; o < NP; o++) begin
                checks++;
                if (out_valid[o] !== exp_v[o]) fail($sformatf("out_valid[%0d]", o), 64'(out_valid[o]), 64'(exp_v[o]));
                else if (exp_v[o] && out_cell[o*CW +: CW] !== exp_d[o])
                    fail($sformatf("out_cell[%0d]", o), 64'(out_cell[o*CW +: CW]), 64'(exp_d[o]));
                if (out_valid[o] === 1'b1) seen[o]++;
            end
            checks++;
            if (drop_count !== DW'(mdrop)) fail("drop_count", 64'(drop_count), 64'(mdrop));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic put(input int i, input int conn);
        in_valid[i] = 1'b1;
        in_conn[i*XW +: XW] = XW'(conn);
        in_cell[i*CW +: CW] = CW'(pay_seq);
        pay_seq++;
    endtask

    task automatic clr();
        in_valid = '0;
        tbl_we = 1'b0;
    endtask

    task automatic prog(input int a, input logic [NP-1:0] msk);
        tbl_we = 1'b1;
        tbl_addr = XW'(a);
        tbl_mask = msk;
        tick();
        tbl_we = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        idle(3);
        // R1: reset values, checked directly in the first cycle out of reset
        rst = 1'b0;
        tick();
        checks++;
        if (out_valid !== '0) fail("out_valid after reset", 64'(out_valid), 64'd0);
        checks++;
        if (drop_count !== '0) fail("drop_count after reset", 64'(drop_count), 64'd0);
        // R1: unprogrammed table discards
        cur_req = "R1";
        for (int i = 0; i < NP; i++) put(i, 5);
        tick(); clr(); idle(3);

        prog(1, 4'b0001); prog(2, 4'b0010); prog(3, 4'b0100); prog(4, 4'b1000);
        prog(5, 4'b1011); prog(6, 4'b1111); prog(7, 4'b0000); prog(8, 4'b0011);

        // R3: outlets 0,1,3 each once, outlet 2 never
        cur_req = "R3";
        for (int o = 0; o < NP; o++) seen[o] = 0;
        put(2, 5); tick(); clr(); idle(5);
        for (int o = 0; o < NP; o++) begin
            checks++;
            if (seen[o] != ((o == 2) ? 0 : 1)) fail($sformatf("copies on outlet %0d", o), 64'(seen[o]), 64'((o == 2) ? 0 : 1));
        end

        // R2: latency to an idle outlet
        cur_req = "R2";
        put(3, 2); tick(); clr();
        checks++;
        if (out_valid !== '0) fail("out_valid one edge after arrival", 64'(out_valid), 64'd0);
        tick();
        checks++;
        if (out_valid !== 4'b0010) fail("out_valid two edges after arrival", 64'(out_valid), 64'b0010);
        idle(3);

        // R4: same-slot arrivals to one outlet leave in inlet order
        cur_req = "R4";
        for (int i = 0; i < NP; i++) put(i, 3);
        tick(); clr(); idle(6);
        put(1, 6); put(2, 6); tick(); clr(); idle(5);

        // R5: empty masks are discarded without drop
        cur_req = "R5";
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < NP; i++) put(i, (i % 2 == 0) ? 7 : 0);
            tick();
        end
        clr();
        checks++;
        if (drop_count !== '0) fail("drop_count after empty masks", 64'(drop_count), 64'd0);
        idle(3);

        // R6: queue fill on one outlet
        cur_req = "R6";
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < NP; i++) put(i, 1);
            tick();
        end
        clr(); idle(12);

        // R7: store exhaustion, then full recovery
        cur_req = "R7";
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < NP; i++) put(i, 1 + (k % 4));
            tick();
        end
        clr(); idle(14);
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < NP; i++) put(i, 6);
            tick();
        end
        clr(); idle(20);

        // R8: table rewrite while cells are queued
        cur_req = "R8";
        for (int i = 0; i < NP; i++) put(i, 8);
        tbl_we = 1'b1; tbl_addr = 4'd8; tbl_mask = 4'b1100;
        tick(); clr();
        for (int i = 0; i < NP; i++) put(i, 8);
        tick(); clr(); idle(10);

        // R6: mixed random traffic with occasional table writes
        cur_req = "R6";
        for (int k = 0; k < 600; k++) begin
            for (int i = 0; i < NP; i++)
                if ($urandom_range(0, 99) < 70) put(i, $urandom_range(0, 9));
            if ($urandom_range(0, 49) == 0) begin
                tbl_we = 1'b1;
                tbl_addr = XW'($urandom_range(1, 9));
                tbl_mask = NP'($urandom_range(0, 15));
            end
            tick(); clr();
        end
        idle(40);
        finish_run();
    end

endmodule